// File: doc/BRIEF.md
# Hash Engine Control and Status Registers

This block is the register front end of a hash accelerator. A simple 32-bit register bus writes and reads a small window of word registers: a source address, a destination address, a key buffer pointer, a source length, a crypt command word, a hash command word and a status word. Each register keeps only the bits its write mask allows, so software always reads back the masked value.

A write to the hash command register decodes the algorithm field, which has two levels: a family code, and for the 512-bit family a sub-variant code. A legal selection produces a one-cycle start pulse toward the hash datapath. The decoded algorithm, the mode and the scatter-gather flag are presented with the pulse. An illegal selection is stored but starts nothing. When the datapath reports completion, the block sets a sticky done flag in the status word. It raises the interrupt line only if the last command enabled it. Software clears both by writing one to the done bit.

Top module: `hash_ctl_regs`

## Requirements
- R1: The word registers sit at byte offsets 0x10 (crypt command, all 32 bits kept), 0x20 (source address, keeps bits [30:0]), 0x28 (key pointer, keeps bits [30:3]) and 0x30 (hash command). A read returns the masked value last written.
- R2: The destination register at 0x24 always reads with bits [2:0] zero and keeps bits [30:3]. The length register at 0x2C keeps only bits [27:0].
- R3: Command bits [6:4] pick the family: 000, 010, 100 and 101 give output codes 0, 1, 2 and 3 (MD5, SHA-1, SHA-224, SHA-256). Family 110 reads bits [12:10]: 000 gives code 5 (SHA-512), 001 gives code 4 (SHA-384) and 010 gives code 3 (SHA-256).
- R4: Any other family or sub-variant code is invalid. The command word is still stored, but no start pulse follows.
- R5: A valid command write gives a start pulse for exactly one cycle, in the cycle after the write. With the pulse come the mode (command bits [8:7]: 0 digest, 1 keyed, 2 accumulate, 3 key setup) and the scatter-gather flag (bit 18).
- R6: A completion pulse sets status bit 9 (byte offset 0x1C) in all cases. The interrupt line rises only if command bit 9 was set.
- R7: Writing one to status bit 9 clears the flag and drops the interrupt. Writing zero there changes nothing. A completion in the same cycle as the clear wins, and the flag stays set.
- R8: A read at a word offset above 0x30 returns zero. A write there changes no register.
- R9: Reset clears every register and the done flag, and leaves the interrupt and start lines low.
- R10: The command mask parameter can drop bits [18] and [12:10]. With such a mask, family 110 decodes as invalid and the scatter-gather bit reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrite | input | 1 | Write strobe for one cycle |
| busRead | input | 1 | Read enable; read data is combinational |
| busAddr | input | ADDR_W | Byte address, word aligned |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, zero when not reading |
| hashStart | output | 1 | One-cycle start toward the datapath |
| hashAlgo | output | 3 | Decoded algorithm code, held from the last start |
| hashMode | output | 2 | Mode code, held from the last start |
| hashSg | output | 1 | Scatter-gather flag, held from the last start |
| hashDone | input | 1 | Completion pulse from the datapath |
| irqOut | output | 1 | Interrupt line |

## Verification
The assertions take four things for granted about the inputs. Addresses are word aligned. The completion input is a single-cycle pulse. No completion arrives in the same cycle as a command write, since the interrupt decision uses the command held before that edge. Read data is only looked at while the read enable is high. The stimulus drives aligned addresses only and issues completion pulses one cycle wide, well after the command write that preceded them. It exercises the one allowed overlap, a clear colliding with a completion, on purpose.

// File: rtl/hre_pkg.sv
package hre_pkg;

  // Word indices inside the register window (byte offset / 4).
  localparam logic [3:0] IDX_CRYPT  = 4'd4;
  localparam logic [3:0] IDX_STATUS = 4'd7;
  localparam logic [3:0] IDX_SRC    = 4'd8;
  localparam logic [3:0] IDX_DST    = 4'd9;
  localparam logic [3:0] IDX_KEY    = 4'd10;
  localparam logic [3:0] IDX_LEN    = 4'd11;
  localparam logic [3:0] IDX_CMD    = 4'd12;

  // Bit positions that neighbouring logic decodes.
  localparam int DONE_BIT   = 9;
  localparam int IRQ_EN_BIT = 9;
  localparam int SG_BIT     = 18;

  typedef enum logic [2:0] {
    ALG_MD5    = 3'd0,
    ALG_SHA1   = 3'd1,
    ALG_SHA224 = 3'd2,
    ALG_SHA256 = 3'd3,
    ALG_SHA384 = 3'd4,
    ALG_SHA512 = 3'd5
  } hashAlgoE;

  typedef enum logic [1:0] {
    MODE_DIGEST = 2'd0,
    MODE_KEYED  = 2'd1,
    MODE_ACCUM  = 2'd2,
    MODE_KEYSET = 2'd3
  } hashModeE;

  // Strobes from the bus decoder to the register datapath.
  typedef struct packed {
    logic wrCrypt;
    logic wrStatus;
    logic wrSrc;
    logic wrDst;
    logic wrKey;
    logic wrLen;
    logic wrCmd;
  } regStrobeT;

endpackage

// File: rtl/hre_ctrl.sv
module hre_ctrl
  import hre_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobeT         strobe,
  output logic [3:0]        rdIdx,
  output logic              rdHit
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              inRange;
  logic              wrHit;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign inRange = (wordIdx <= WORD_W'(IDX_CMD));
  assign rdIdx   = wordIdx[3:0];
  assign rdHit   = busRead && inRange;
  assign wrHit   = busWrite && inRange;

  always_comb begin
    strobe          = '0;
    strobe.wrCrypt  = wrHit && (rdIdx == IDX_CRYPT);
    strobe.wrStatus = wrHit && (rdIdx == IDX_STATUS);
    strobe.wrSrc    = wrHit && (rdIdx == IDX_SRC);
    strobe.wrDst    = wrHit && (rdIdx == IDX_DST);
    strobe.wrKey    = wrHit && (rdIdx == IDX_KEY);
    strobe.wrLen    = wrHit && (rdIdx == IDX_LEN);
    strobe.wrCmd    = wrHit && (rdIdx == IDX_CMD);
  end

endmodule

// File: rtl/hre_cmd_decode.sv
module hre_cmd_decode
  import hre_pkg::*;
#(
  parameter logic [31:0] CMD_MASK = 32'h0014_7FFF
) (
  input  logic [2:0] famSel,
  input  logic [2:0] subSel,
  output logic       valid,
  output hashAlgoE   algo
);

  // The 512-bit family exists only when its sub-variant field survives the mask.
  localparam bit WIDE_OK = (CMD_MASK[12:10] == 3'b111);

  always_comb begin
    valid = 1'b1;
    algo  = ALG_MD5;
    unique case (famSel)
      3'b000: algo = ALG_MD5;
      3'b010: algo = ALG_SHA1;
      3'b100: algo = ALG_SHA224;
      3'b101: algo = ALG_SHA256;
      3'b110: begin
        if (!WIDE_OK) begin
          valid = 1'b0;
        end else begin
          unique case (subSel)
            3'b000:  algo = ALG_SHA512;
            3'b001:  algo = ALG_SHA384;
            3'b010:  algo = ALG_SHA256;
            default: valid = 1'b0;
          endcase
        end
      end
      default: valid = 1'b0;
    endcase
  end

endmodule

// File: rtl/hre_regs.sv
module hre_regs
  import hre_pkg::*;
#(
  parameter logic [31:0] SRC_MASK = 32'h7FFF_FFFF,
  parameter logic [31:0] DST_MASK = 32'h7FFF_FFF8,
  parameter logic [31:0] KEY_MASK = 32'h7FFF_FFF8,
  parameter logic [31:0] LEN_MASK = 32'h0FFF_FFFF,
  parameter logic [31:0] CMD_MASK = 32'h0014_7FFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  regStrobeT   strobe,
  input  logic [31:0] wdata,
  input  logic [3:0]  rdIdx,
  input  logic        rdHit,
  input  logic        hashDone,
  output logic [31:0] rdata,
  output logic        hashStart,
  output hashAlgoE    hashAlgo,
  output hashModeE    hashMode,
  output logic        hashSg,
  output logic        irqOut
);

  logic [31:0] cryptReg, srcReg, dstReg, keyReg, lenReg, cmdReg;
  logic [31:0] cmdNext;
  logic        doneFlag;
  logic        decValid;
  hashAlgoE    decAlgo;
  logic        clearHit;
  logic        irqSet;

  assign cmdNext  = wdata & CMD_MASK;
  assign clearHit = strobe.wrStatus && wdata[DONE_BIT];
  assign irqSet   = hashDone && cmdReg[IRQ_EN_BIT];

  hre_cmd_decode #(.CMD_MASK(CMD_MASK)) uDecode (
    .famSel(cmdNext[6:4]),
    .subSel(cmdNext[12:10]),
    .valid (decValid),
    .algo  (decAlgo)
  );

  // Plain storage registers, each with its own write mask.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cryptReg <= '0;
      srcReg   <= '0;
      dstReg   <= '0;
      keyReg   <= '0;
      lenReg   <= '0;
      cmdReg   <= '0;
    end else begin
      if (strobe.wrCrypt) cryptReg <= wdata;
      if (strobe.wrSrc)   srcReg   <= wdata & SRC_MASK;
      if (strobe.wrDst)   dstReg   <= wdata & DST_MASK;
      if (strobe.wrKey)   keyReg   <= wdata & KEY_MASK;
      if (strobe.wrLen)   lenReg   <= wdata & LEN_MASK;
      if (strobe.wrCmd)   cmdReg   <= cmdNext;
    end
  end

  // Start pulse and the selection held alongside it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hashStart <= 1'b0;
      hashAlgo  <= ALG_MD5;
      hashMode  <= MODE_DIGEST;
      hashSg    <= 1'b0;
    end else begin
      hashStart <= strobe.wrCmd && decValid;
      if (strobe.wrCmd && decValid) begin
        hashAlgo <= decAlgo;
        hashMode <= hashModeE'(cmdNext[8:7]);
        hashSg   <= cmdNext[SG_BIT];
      end
    end
  end

  // Completion flag and interrupt: a completion wins over a clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      irqOut   <= 1'b0;
    end else begin
      if (hashDone)      doneFlag <= 1'b1;
      else if (clearHit) doneFlag <= 1'b0;
      if (irqSet)                    irqOut <= 1'b1;
      else if (clearHit && doneFlag) irqOut <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rdHit) begin
      case (rdIdx)
        IDX_CRYPT:  rdata = cryptReg;
        IDX_STATUS: rdata[DONE_BIT] = doneFlag;
        IDX_SRC:    rdata = srcReg;
        IDX_DST:    rdata = dstReg;
        IDX_KEY:    rdata = keyReg;
        IDX_LEN:    rdata = lenReg;
        IDX_CMD:    rdata = cmdReg;
        default:    rdata = '0;
      endcase
    end
  end

  assert_start_from_cmd_R5: assert property (@(posedge clk) disable iff (!rstN)
    hashStart |-> $past(strobe.wrCmd && decValid));

  assert_invalid_nostart_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrCmd && !decValid) |=> !hashStart);

  assert_done_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    hashDone |=> doneFlag);

  assert_irq_needs_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> doneFlag);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (clearHit && !hashDone) |=> (!doneFlag && !irqOut));

  assert_oob_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdHit |-> (rdata == 32'h0));

  assert_dst_align_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rdHit && rdIdx == IDX_DST) |-> (rdata[2:0] == 3'b000));

endmodule

// File: rtl/hash_ctl_regs.sv
module hash_ctl_regs
  import hre_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] SRC_MASK = 32'h7FFF_FFFF,
  parameter logic [31:0] DST_MASK = 32'h7FFF_FFF8,
  parameter logic [31:0] KEY_MASK = 32'h7FFF_FFF8,
  parameter logic [31:0] LEN_MASK = 32'h0FFF_FFFF,
  parameter logic [31:0] CMD_MASK = 32'h0014_7FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              hashStart,
  output logic [2:0]        hashAlgo,
  output logic [1:0]        hashMode,
  output logic              hashSg,
  input  logic              hashDone,
  output logic              irqOut
);

  regStrobeT  strobe;
  logic [3:0] rdIdx;
  logic       rdHit;
  hashAlgoE   algoSel;
  hashModeE   modeSel;

  hre_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busWrite(busWrite),
    .busRead (busRead),
    .busAddr (busAddr),
    .strobe  (strobe),
    .rdIdx   (rdIdx),
    .rdHit   (rdHit)
  );

  hre_regs #(
    .SRC_MASK(SRC_MASK),
    .DST_MASK(DST_MASK),
    .KEY_MASK(KEY_MASK),
    .LEN_MASK(LEN_MASK),
    .CMD_MASK(CMD_MASK)
  ) uRegs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wdata    (busWdata),
    .rdIdx    (rdIdx),
    .rdHit    (rdHit),
    .hashDone (hashDone),
    .rdata    (busRdata),
    .hashStart(hashStart),
    .hashAlgo (algoSel),
    .hashMode (modeSel),
    .hashSg   (hashSg),
    .irqOut   (irqOut)
  );

  assign hashAlgo = algoSel;
  assign hashMode = modeSel;

endmodule

// File: tb/sim_hash_ctl_regs.sv
`timescale 1ns/1ps
module sim_hash_ctl_regs;

  localparam int AW = 12;
  localparam logic [31:0] M_SRC = 32'h7FFF_FFFF;
  localparam logic [31:0] M_DST = 32'h7FFF_FFF8;
  localparam logic [31:0] M_KEY = 32'h7FFF_FFF8;
  localparam logic [31:0] M_LEN = 32'h0FFF_FFFF;
  localparam logic [31:0] M_CMD = 32'h0014_7FFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic          busWrite = 0, busRead = 0, hashDone = 0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWdata = '0, busRdata;
  logic          hashStart, hashSg, irqOut;
  logic [2:0]    hashAlgo;
  logic [1:0]    hashMode;

  logic          b1Write = 0, b1Read = 0;
  logic [AW-1:0] b1Addr = '0;
  logic [31:0]   b1Wdata = '0, b1Rdata;
  logic          s1Start, s1Sg, s1Irq;
  logic [2:0]    s1Algo;
  logic [1:0]    s1Mode;

  hash_ctl_regs #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busRead(busRead),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .hashStart(hashStart), .hashAlgo(hashAlgo), .hashMode(hashMode),
    .hashSg(hashSg), .hashDone(hashDone), .irqOut(irqOut));

  hash_ctl_regs #(.ADDR_W(AW), .CMD_MASK(32'h0000_03FF)) u1 (
    .clk(clk), .rstN(rstN), .busWrite(b1Write), .busRead(b1Read),
    .busAddr(b1Addr), .busWdata(b1Wdata), .busRdata(b1Rdata),
    .hashStart(s1Start), .hashAlgo(s1Algo), .hashMode(s1Mode),
    .hashSg(s1Sg), .hashDone(1'b0), .irqOut(s1Irq));

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model of u0.
  logic [31:0] mCrypt, mSrc, mDst, mKey, mLen, mCmd;
  bit mDone, mIrq, mStart, mSg;
  int mAlgo, mMode;

  function automatic void refDecode(input logic [31:0] c, output bit ok, output int alg);
    ok = 1; alg = 0;
    case (c[6:4])
      3'b000: alg = 0;
      3'b010: alg = 1;
      3'b100: alg = 2;
      3'b101: alg = 3;
      3'b110: case (c[12:10])
                3'b000: alg = 5;
                3'b001: alg = 4;
                3'b010: alg = 3;
                default: ok = 0;
              endcase
      default: ok = 0;
    endcase
  endfunction

  function automatic logic [31:0] refRead(input logic [AW-1:0] a);
    case (int'(a) / 4)
      4: return mCrypt;
      7: return {22'd0, mDone, 9'd0};
      8: return mSrc;
      9: return mDst;
      10: return mKey;
      11: return mLen;
      12: return mCmd;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCrypt <= 0; mSrc <= 0; mDst <= 0; mKey <= 0; mLen <= 0; mCmd <= 0;
      mDone <= 0; mIrq <= 0; mStart <= 0; mSg <= 0; mAlgo <= 0; mMode <= 0;
    end else begin
      bit ok; int alg; bit clr;
      clr = busWrite && (int'(busAddr) == 'h1C) && busWdata[9];
      mStart <= 0;
      if (busWrite) begin
        case (int'(busAddr))
          'h10: mCrypt <= busWdata;
          'h20: mSrc <= busWdata & M_SRC;
          'h24: mDst <= busWdata & M_DST;
          'h28: mKey <= busWdata & M_KEY;
          'h2C: mLen <= busWdata & M_LEN;
          'h30: begin
            mCmd <= busWdata & M_CMD;
            refDecode(busWdata & M_CMD, ok, alg);
            if (ok) begin
              mStart <= 1; mAlgo <= alg;
              mMode <= int'(busWdata[8:7]); mSg <= busWdata[18];
            end
          end
          default: ;
        endcase
      end
      if (hashDone) mDone <= 1; else if (clr) mDone <= 0;
      if (hashDone && mCmd[9]) mIrq <= 1; else if (clr && mDone) mIrq <= 0;
    end
  end

  // Compare against the model every cycle, away from the clock edge.
  always begin
    @(negedge clk); #1;
    if (rstN && !finished) begin
      chk("R5 start pulse", {31'd0, hashStart}, {31'd0, mStart});
      if (mStart) begin
        chk("R3 algorithm code", {29'd0, hashAlgo}, mAlgo);
        chk("R5 mode", {30'd0, hashMode}, mMode);
        chk("R5 scatter-gather", {31'd0, hashSg}, {31'd0, mSg});
      end
      chk("R6 interrupt", {31'd0, irqOut}, {31'd0, mIrq});
      if (busRead) chk("R1 read data", busRdata, refRead(busAddr));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    busWrite = 1; busRead = 0; busAddr = AW'(a); busWdata = d;
    @(negedge clk);
    busWrite = 0;
    #1;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    busWrite = 0; busRead = 1; busAddr = AW'(a);
    #1 d = busRdata;
  endtask

  task automatic pulseDone();
    @(negedge clk); busRead = 0; hashDone = 1;
    @(negedge clk); hashDone = 0;
    #1;
  endtask

  task automatic cmdExpect(input logic [31:0] c, input bit exStart, input int exAlgo, input string tag);
    wr('h30, c);
    chk(tag, {31'd0, hashStart}, {31'd0, exStart});
    if (exStart) chk({tag, " code"}, {29'd0, hashAlgo}, exAlgo);
  endtask

  task automatic wr1(input int a, input logic [31:0] d);
    @(negedge clk);
    b1Write = 1; b1Addr = AW'(a); b1Wdata = d;
    @(negedge clk);
    b1Write = 0;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;

    // R9: reset state
    for (int a = 'h10; a <= 'h30; a += 4) begin
      rd(a, d); chk("R9 register zero after reset", d, 32'h0);
    end
    chk("R9 irq low after reset", {31'd0, irqOut}, 32'h0);
    chk("R9 start low after reset", {31'd0, hashStart}, 32'h0);

    // R1: masks and offsets
    wr('h20, 32'hFFFF_FFFF); rd('h20, d); chk("R1 source mask", d, 32'h7FFF_FFFF);
    wr('h28, 32'hFFFF_FFFF); rd('h28, d); chk("R1 key mask", d, 32'h7FFF_FFF8);
    wr('h10, 32'hDEAD_BEEF); rd('h10, d); chk("R1 crypt word", d, 32'hDEAD_BEEF);

    // R2: destination alignment and length width
    wr('h24, 32'h1234_567F); rd('h24, d); chk("R2 destination aligned", d, 32'h1234_5678);
    wr('h2C, 32'hFFFF_FFFF); rd('h2C, d); chk("R2 length width", d, 32'h0FFF_FFFF);

    // R3: every legal selection
    cmdExpect(32'h000, 1, 0, "R3 md5");
    cmdExpect(32'h020, 1, 1, "R3 sha1");
    cmdExpect(32'h040, 1, 2, "R3 sha224");
    cmdExpect(32'h050, 1, 3, "R3 sha256");
    cmdExpect(32'h060, 1, 5, "R3 sha512");
    cmdExpect(32'h460, 1, 4, "R3 sha384");
    cmdExpect(32'h860, 1, 3, "R3 wide sha256");

    // R4: illegal selections start nothing but are stored
    cmdExpect(32'h010, 0, 0, "R4 family 001");
    cmdExpect(32'h030, 0, 0, "R4 family 011");
    cmdExpect(32'h070, 0, 0, "R4 family 111");
    cmdExpect(32'hC60, 0, 0, "R4 sub 011");
    cmdExpect(32'h1060, 0, 0, "R4 sub 100");
    rd('h30, d); chk("R4 invalid command stored", d, 32'h1060);

    // R5: fields travel with a single-cycle pulse
    wr('h30, 32'h0004_0150);
    chk("R5 pulse present", {31'd0, hashStart}, 32'h1);
    chk("R5 accumulate mode", {30'd0, hashMode}, 32'h2);
    chk("R5 sg flag", {31'd0, hashSg}, 32'h1);
    @(negedge clk); #1;
    chk("R5 pulse one cycle", {31'd0, hashStart}, 32'h0);

    // R6: completion without interrupt enable
    wr('h30, 32'h050);
    repeat (2) @(negedge clk);
    pulseDone();
    rd('h1C, d); chk("R6 status set, irq disabled", d, 32'h200);
    chk("R6 irq stays low", {31'd0, irqOut}, 32'h0);
    // R7: clear by writing one
    wr('h1C, 32'h200); rd('h1C, d); chk("R7 status cleared", d, 32'h0);

    // R6/R7: completion with interrupt enable
    wr('h30, 32'h250);
    repeat (2) @(negedge clk);
    pulseDone();
    chk("R6 irq raised", {31'd0, irqOut}, 32'h1);
    wr('h1C, 32'h0); rd('h1C, d); chk("R7 zero write keeps status", d, 32'h200);
    chk("R7 zero write keeps irq", {31'd0, irqOut}, 32'h1);
    wr('h1C, 32'h200); rd('h1C, d); chk("R7 cleared", d, 32'h0);
    chk("R7 irq dropped", {31'd0, irqOut}, 32'h0);

    // R7: completion colliding with a clear
    pulseDone();
    @(negedge clk);
    busWrite = 1; busAddr = AW'('h1C); busWdata = 32'h200; hashDone = 1;
    @(negedge clk);
    busWrite = 0; hashDone = 0;
    #1;
    rd('h1C, d); chk("R7 completion wins over clear", d, 32'h200);
    chk("R7 irq held on collision", {31'd0, irqOut}, 32'h1);
    wr('h1C, 32'h200);

    // R8: outside the window
    wr('h40, 32'hFFFF_FFFF);
    rd('h40, d); chk("R8 read above window", d, 32'h0);
    rd('h34, d); chk("R8 read just past last", d, 32'h0);
    rd('hFFC, d); chk("R8 read top of space", d, 32'h0);
    rd('h20, d); chk("R8 write outside changes nothing", d, 32'h7FFF_FFFF);

    // R10: reduced command mask
    wr1('h30, 32'h060);
    chk("R10 wide family invalid", {31'd0, s1Start}, 32'h0);
    wr1('h30, 32'h0004_0050);
    chk("R10 narrow start", {31'd0, s1Start}, 32'h1);
    chk("R10 sg hidden", {31'd0, s1Sg}, 32'h0);
    @(negedge clk); b1Read = 1; b1Addr = AW'('h30); #1;
    chk("R10 command readback masked", b1Rdata, 32'h050);
    b1Read = 0;

    // R9: reset in mid-run
    wr('h20, 32'h55);
    pulseDone();
    @(negedge clk); busRead = 0; rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1; #1;
    rd('h20, d); chk("R9 source cleared by reset", d, 32'h0);
    rd('h1C, d); chk("R9 status cleared by reset", d, 32'h0);
    chk("R9 irq low after reset", {31'd0, irqOut}, 32'h0);

    @(negedge clk); busRead = 0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule